// File: doc/BRIEF.md
# Port Change Interrupt Detector

This block watches the upper half of an 8-bit general-purpose input port and raises a sticky change flag when any of those four pins no longer matches the value captured by the most recent port read. Software reads the port, and that read refreshes a 4-bit compare latch. Any later difference on the watched pins sets the flag. The flag stays set until software writes it clear. An interrupt request leaves the block only when both a change-interrupt enable and a global interrupt enable are set.

Raw pin levels pass through a two-stage synchronizer. The synchronized value drives both the port read data and the comparison. Detection is armed only while every pin of the upper nibble is configured as an input. The lower four pins can be read but never affect the flag.

Top module: `port_change_irq`

## Requirements
- R1: After reset the change flag, the interrupt request, both enables and the compare latch are 0. A latch of 0 means a nonzero upper nibble on input pins sets the flag once it has been synchronized.
- R2: Pins 3..0 never set the change flag, whatever values they take.
- R3: With detection armed, a difference between any synchronized pin 7..4 and the matching compare-latch bit sets the flag. A pin change applied before clock edge k is seen as the flag after edge k+2, which counts two synchronizer stages plus the flag register.
- R4: Detection is armed only when dir_in[7:4] is 4'b1111 (1 = input). With any of those four bits at 0, no mismatch sets the flag.
- R5: A cycle with rd_stb high loads the synchronized pins 7..4 into the compare latch at that edge. From then on, those pin values cause no mismatch.
- R6: The flag is sticky. It stays 1 until a cycle with flag_clr high and no mismatch. If a mismatch is present in the same cycle, setting wins and the flag stays 1.
- R7: irq is 1 exactly when the flag, the change enable and the global enable are all 1. A clear global enable blocks the request even while the flag is set.
- R8: A cycle with ctl_wr high loads ctl_chg_en and ctl_glb_en into the two enable registers. rd_data shows the synchronized pins two edges after a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 8 | Raw port pin levels |
| dir_in | input | 8 | Per-pin direction, 1 = input |
| rd_stb | input | 1 | Port read strobe; loads the compare latch |
| ctl_wr | input | 1 | Enable register write strobe |
| ctl_chg_en | input | 1 | Change-interrupt enable value to write |
| ctl_glb_en | input | 1 | Global interrupt enable value to write |
| flag_clr | input | 1 | Write-clear of the change flag |
| rd_data | output | 8 | Synchronized port value |
| chg_flag | output | 1 | Sticky change flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle: the flag is cleared by reset, an armed mismatch always sets the flag on the next edge, the flag cannot rise while the upper direction bits are not all inputs, the flag stays set unless cleared, and the request never appears without both enables. Only the bench's scenarios can show end-to-end behaviour. This covers the three-edge latency from pin to flag, how a read refreshes the latch, and that the lower pins are ignored. It also covers the full sweep of old and new nibble pairs and the clear that loses to a persisting mismatch.

// File: rtl/port_change_irq.sv
module port_change_irq #(
  parameter int W = 8,
  parameter int LO = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] dir_in,
  input  logic         rd_stb,
  input  logic         ctl_wr,
  input  logic         ctl_chg_en,
  input  logic         ctl_glb_en,
  input  logic         flag_clr,
  output logic [W-1:0] rd_data,
  output logic         chg_flag,
  output logic         irq
);
  localparam int NW = W - LO;

  logic [W-1:0]  pin_s1, pin_s2;
  logic [NW-1:0] cmp_q;
  logic          chg_en_q, glb_en_q, flag_q;
  logic          armed, mismatch;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_s1 <= '0;
      pin_s2 <= '0;
    end else begin
      pin_s1 <= pin_in;
      pin_s2 <= pin_s1;
    end

  assign armed    = &dir_in[W-1:LO];
  assign mismatch = armed && (|(pin_s2[W-1:LO] ^ cmp_q));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cmp_q <= '0;
    else if (rd_stb) cmp_q <= pin_s2[W-1:LO];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      chg_en_q <= 1'b0;
      glb_en_q <= 1'b0;
    end else if (ctl_wr) begin
      chg_en_q <= ctl_chg_en;
      glb_en_q <= ctl_glb_en;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flag_q <= 1'b0;
    else if (mismatch) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;

  assign rd_data  = pin_s2;
  assign chg_flag = flag_q;
  assign irq      = flag_q & chg_en_q & glb_en_q;
endmodule

module port_change_irq_chk #(
  parameter int W = 8,
  parameter int LO = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  dir_in,
  input logic          flag_clr,
  input logic          chg_flag,
  input logic          irq,
  input logic          chg_en_q,
  input logic          glb_en_q,
  input logic [W-1:0]  pin_s2,
  input logic [W-LO-1:0] cmp_q
);
  a_r1_reset_clears: assert property (@(posedge clk) !rst_n |=> (!chg_flag && !irq));
  a_r3_mismatch_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((&dir_in[W-1:LO]) && (pin_s2[W-1:LO] != cmp_q)) |=> chg_flag);
  a_r4_disarmed_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_flag && !(&dir_in[W-1:LO])) |=> !chg_flag);
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !flag_clr) |=> chg_flag);
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (chg_flag && chg_en_q && glb_en_q));
endmodule

bind port_change_irq port_change_irq_chk #(.W(W), .LO(LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .flag_clr(flag_clr),
  .chg_flag(chg_flag), .irq(irq), .chg_en_q(chg_en_q), .glb_en_q(glb_en_q),
  .pin_s2(pin_s2), .cmp_q(cmp_q)
);

// File: tb/port_change_irq_bench.sv
module port_change_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_in = '0, dir_in = 8'hFF;
  logic       rd_stb = 0, ctl_wr = 0, ctl_chg_en = 0, ctl_glb_en = 0, flag_clr = 0;
  logic [7:0] rd_data;
  logic       chg_flag, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  port_change_irq u_port_change_irq (.*);

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read();
    rd_stb = 1; tick(1); rd_stb = 0;
  endtask

  task automatic do_clr();
    flag_clr = 1; tick(1); flag_clr = 0;
  endtask

  task automatic set_en(logic c, logic g);
    ctl_chg_en = c; ctl_glb_en = g; ctl_wr = 1; tick(1); ctl_wr = 0;
  endtask

  task automatic settle(logic [7:0] p);
    pin_in = p; tick(3); do_read(); do_clr();
  endtask

  initial begin
    tick(3);
    chk("R1 flag", {7'd0, chg_flag}, 8'd0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rst_n = 1;
    pin_in = 8'h0F; tick(3);
    chk("R1 latch zero, low pins", {7'd0, chg_flag}, 8'd0);
    pin_in = 8'h10; tick(2);
    chk("R8 rd_data latency", rd_data, 8'h10);
    chk("R3 not yet", {7'd0, chg_flag}, 8'd0);
    tick(1);
    chk("R3 flag after three edges", {7'd0, chg_flag}, 8'd1);
    chk("R7 enables off", {7'd0, irq}, 8'd0);
    for (int e = 0; e < 4; e++) begin
      set_en(e[0], e[1]);
      chk("R7 irq gating", {7'd0, irq}, {7'd0, e[0] & e[1]});
    end
    do_clr();
    chk("R6 clear with live mismatch", {7'd0, chg_flag}, 8'd1);
    do_read(); do_clr();
    chk("R5 read refreshes latch", {7'd0, chg_flag}, 8'd0);
    chk("R7 no flag no irq", {7'd0, irq}, 8'd0);
    pin_in = 8'h30; tick(3);
    pin_in = 8'h10; tick(6);
    chk("R6 sticky after pins return", {7'd0, chg_flag}, 8'd1);
    do_clr();
    chk("R6 clear when matched", {7'd0, chg_flag}, 8'd0);
    for (int lo = 0; lo < 16; lo++) begin
      pin_in = {4'h1, lo[3:0]}; tick(4);
      chk("R2 low pins ignored", {7'd0, chg_flag}, 8'd0);
      chk("R8 rd_data", rd_data, {4'h1, lo[3:0]});
    end
    for (int d = 0; d < 16; d++) begin
      dir_in = 8'hFF; settle(8'h00);
      dir_in = {d[3:0], 4'h0};
      pin_in = 8'hF0; tick(4);
      chk("R4 direction gating", {7'd0, chg_flag}, {7'd0, d == 15});
      dir_in = 8'hFF; settle(8'hF0);
    end
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        settle({a[3:0], 4'h0});
        chk("R5 settled", {7'd0, chg_flag}, 8'd0);
        pin_in = {b[3:0], 4'((a * 5 + b) & 15)}; tick(3);
        chk("R3 nibble sweep", {7'd0, chg_flag}, {7'd0, a != b});
      end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); errors++; $display("FAIL watchdog actual=timeout expected=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule